// File: doc/BRIEF.md
# Address-Triggered Soft Switch Bank

This block gives an 8-bit CPU with a 16-bit address bus a set of eight on/off control flags that are changed purely by which address the CPU touches. The data bus plays no part in setting a flag: three address bits choose the flag and the lowest address bit is the value it takes. The bank therefore needs no read-modify-write sequence, and software can flip any flag with a single access of any kind. Every flag owns a pair of neighbouring addresses: the even one turns it off and the odd one turns it on.

All of the block's decoding takes place inside one 256-byte I/O page. The lower half of the page holds the motherboard functions. These are the 16-byte switch group, a read-only keyboard port and a strobe-clear address. The upper half is split into eight 16-byte peripheral slots. For those slots the block only raises a one-hot select line and leaves the data bus alone. The keyboard port returns the latched 7-bit key code in bits 6:0 and a key-available flag in bit 7.

Top module: `softsw_bank`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears all eight switches and the key-available flag.
- R2: A qualified access (bus_valid high) to page 0xC0, offsets 0x50..0x5F, sets switch number addr[3:1] to the value addr[0] at the rising edge that ends the cycle. Value 0 means off and 1 means on.
- R3: Read cycles (bus_rw=1) and write cycles (bus_rw=0) update a switch in the same way. No data value is involved.
- R4: A switch access changes only the addressed switch. The other seven keep their values.
- R5: During a read of a switch address, bus_rdata_oe is high and bus_rdata carries the eight switch states as they stood before that cycle's edge. Switch k appears on bit k.
- R6: A one-cycle key_valid pulse latches key_code and sets the key-available flag. A later read of offset 0x00 returns {flag, code}, with the flag in bit 7.
- R7: Any qualified access to offset 0x10 clears the key-available flag and keeps the latched code. If key_valid arrives in the same cycle, key_valid wins and the flag stays set.
- R8: An access outside page 0xC0, or any cycle with bus_valid low, leaves every switch unchanged and keeps bus_rdata_oe low.
- R9: A qualified access to the page with addr[7]=1 raises slot_sel[addr[6:4]] in the same cycle, all other select lines stay low, and bus_rdata_oe stays low. Otherwise slot_sel is all zero.
- R10: A read of an unmapped motherboard offset (addr[7]=0, and neither a switch, keyboard nor strobe offset) keeps bus_rdata_oe low and changes no switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the rising edge ends each bus cycle |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | A qualified bus cycle is in progress |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 16 | CPU address |
| bus_rdata | output | 8 | Read data, zero when not driven |
| bus_rdata_oe | output | 1 | The block drives the data bus this cycle |
| key_valid | input | 1 | One-cycle pulse: a new key code is present |
| key_code | input | 7 | Key code that accompanies key_valid |
| sw_state | output | 8 | Current switch flags, one bit per switch |
| slot_sel | output | 8 | One-hot select for the addressed peripheral slot |

## Verification
Read data, the output enable and the slot selects are combinational, so they are due in the same cycle as the access. The bench samples them 1 ns after it drives the address and before the closing edge. Switch states and the key flag pass through one register each and become visible just after the edge that ends the access. The bench samples them 1 ns after that edge. A key pulse is therefore checked through a keyboard read in a later cycle. A strobe is checked by a read in the following cycle, which must still show the old code.

// File: rtl/softsw_pkg.sv
package softsw_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int KEY_W  = 7;

  // high byte of the address selects the I/O page
  function automatic logic page_match(input logic [ADDR_W-1:0] addr,
                                      input logic [7:0]        page);
    return addr[ADDR_W-1:8] == page;
  endfunction

  // keyboard word: availability flag above the code
  function automatic logic [DATA_W-1:0] kbd_word(input logic             avail,
                                                 input logic [KEY_W-1:0] code);
    return {avail, code};
  endfunction

  // one-hot mask for switch index
  function automatic logic [7:0] onehot8(input logic [2:0] idx);
    return 8'b1 << idx;
  endfunction

endpackage

// File: rtl/softsw_decode.sv
module softsw_decode
  import softsw_pkg::*;
#(
  parameter logic [7:0] PAGE_HI = 8'hC0,
  parameter logic [7:0] SW_BASE = 8'h50,
  parameter logic [7:0] KBD_LO  = 8'h00,
  parameter logic [7:0] STB_LO  = 8'h10,
  parameter int         SEL_W   = 3,
  parameter int         SLOTS   = 8
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  output logic              page_hit,
  output logic              sw_hit,
  output logic [SEL_W-1:0]  sw_idx,
  output logic              sw_val,
  output logic              kbd_hit,
  output logic              stb_hit,
  output logic [SLOTS-1:0]  slot_sel
);
  localparam int GRP_LSB = SEL_W + 1;
  localparam int SLOT_W  = $clog2(SLOTS);

  logic mb_half;

  assign page_hit = valid && page_match(addr, PAGE_HI);
  assign mb_half  = page_hit && !addr[7];
  assign sw_hit   = mb_half && (addr[7:GRP_LSB] == SW_BASE[7:GRP_LSB]);
  assign sw_idx   = addr[SEL_W:1];
  assign sw_val   = addr[0];
  assign kbd_hit  = mb_half && (addr[7:0] == KBD_LO);
  assign stb_hit  = mb_half && (addr[7:0] == STB_LO);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign slot_sel[s] = page_hit && addr[7] && (addr[4+SLOT_W-1:4] == SLOT_W'(s));
  end

endmodule

// File: rtl/softsw_latches.sv
module softsw_latches #(
  parameter int SEL_W  = 3,
  parameter int NUM_SW = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_hit,
  input  logic [SEL_W-1:0]  sw_idx,
  input  logic              sw_val,
  output logic [NUM_SW-1:0] sw_q
);

  for (genvar k = 0; k < NUM_SW; k++) begin : g_sw
    always_ff @(posedge clk) begin
      if (rst)
        sw_q[k] <= 1'b0;
      else if (sw_hit && (sw_idx == SEL_W'(k)))
        sw_q[k] <= sw_val;
    end
  end

endmodule

// File: rtl/softsw_kbd.sv
module softsw_kbd
  import softsw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             key_valid,
  input  logic [KEY_W-1:0] key_code,
  input  logic             stb_hit,
  output logic [KEY_W-1:0] code_q,
  output logic             avail_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= '0;
      avail_q <= 1'b0;
    end else if (key_valid) begin
      code_q  <= key_code;
      avail_q <= 1'b1;
    end else if (stb_hit) begin
      avail_q <= 1'b0;
    end
  end

endmodule

// File: rtl/softsw_bank.sv
module softsw_bank
  import softsw_pkg::*;
#(
  parameter logic [7:0] PAGE_HI = 8'hC0,
  parameter logic [7:0] SW_BASE = 8'h50,
  parameter logic [7:0] KBD_LO  = 8'h00,
  parameter logic [7:0] STB_LO  = 8'h10,
  parameter int         SEL_W   = 3,
  parameter int         SLOTS   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_rw,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rdata_oe,
  input  logic              key_valid,
  input  logic [KEY_W-1:0]  key_code,
  output logic [(1<<SEL_W)-1:0] sw_state,
  output logic [SLOTS-1:0]  slot_sel
);
  localparam int NUM_SW = 1 << SEL_W;

  // named internal events, observed by the checker
  logic             page_hit;
  logic             sw_hit;
  logic [SEL_W-1:0] sw_idx;
  logic             sw_val;
  logic             kbd_hit;
  logic             stb_hit;
  logic             key_avail;
  logic [KEY_W-1:0] key_latched;

  softsw_decode #(
    .PAGE_HI(PAGE_HI), .SW_BASE(SW_BASE), .KBD_LO(KBD_LO),
    .STB_LO(STB_LO), .SEL_W(SEL_W), .SLOTS(SLOTS)
  ) u_dec (
    .valid   (bus_valid),
    .addr    (bus_addr),
    .page_hit(page_hit),
    .sw_hit  (sw_hit),
    .sw_idx  (sw_idx),
    .sw_val  (sw_val),
    .kbd_hit (kbd_hit),
    .stb_hit (stb_hit),
    .slot_sel(slot_sel)
  );

  softsw_latches #(.SEL_W(SEL_W), .NUM_SW(NUM_SW)) u_sw (
    .clk   (clk),
    .rst   (rst),
    .sw_hit(sw_hit),
    .sw_idx(sw_idx),
    .sw_val(sw_val),
    .sw_q  (sw_state)
  );

  softsw_kbd u_kbd (
    .clk      (clk),
    .rst      (rst),
    .key_valid(key_valid),
    .key_code (key_code),
    .stb_hit  (stb_hit),
    .code_q   (key_latched),
    .avail_q  (key_avail)
  );

  always_comb begin
    bus_rdata_oe = bus_rw && (sw_hit || kbd_hit || stb_hit);
    bus_rdata    = '0;
    if (bus_rdata_oe) begin
      if (sw_hit)
        bus_rdata = DATA_W'(sw_state);
      else
        bus_rdata = kbd_word(key_avail, key_latched);
    end
  end

endmodule

// File: rtl/softsw_bank_chk.sv
module softsw_bank_chk #(
  parameter logic [7:0] PAGE_HI = 8'hC0,
  parameter logic [7:0] SW_BASE = 8'h50,
  parameter int         SEL_W   = 3,
  parameter int         SLOTS   = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   bus_valid,
  input logic [15:0]            bus_addr,
  input logic                   bus_rdata_oe,
  input logic                   key_valid,
  input logic                   key_avail,
  input logic [(1<<SEL_W)-1:0]  sw_state,
  input logic [SLOTS-1:0]       slot_sel
);
  localparam int GRP_LSB = SEL_W + 1;

  logic in_page;
  logic sw_addr;
  assign in_page = bus_valid && (bus_addr[15:8] == PAGE_HI);
  assign sw_addr = in_page && !bus_addr[7] &&
                   (bus_addr[7:GRP_LSB] == SW_BASE[7:GRP_LSB]);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (sw_state == '0) && !key_avail);

  // R2
  sw_update_chk: assert property (@(posedge clk) disable iff (rst)
    sw_addr |=> sw_state[$past(bus_addr[SEL_W:1])] == $past(bus_addr[0]));

  // R4
  single_change_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid |=> $countones(sw_state ^ $past(sw_state)) <= 1);

  // R8
  outside_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !in_page |=> $stable(sw_state));

  // R8
  outside_nodrive_chk: assert property (@(posedge clk) disable iff (rst)
    !in_page |-> !bus_rdata_oe);

  // R9
  slot_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slot_sel));

  // R9
  slot_nodrive_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_sel != '0) |-> !bus_rdata_oe && bus_addr[7]);

  // R6
  key_flag_chk: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> key_avail);

endmodule

bind softsw_bank softsw_bank_chk #(
  .PAGE_HI(PAGE_HI), .SW_BASE(SW_BASE), .SEL_W(SEL_W), .SLOTS(SLOTS)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_valid   (bus_valid),
  .bus_addr    (bus_addr),
  .bus_rdata_oe(bus_rdata_oe),
  .key_valid   (key_valid),
  .key_avail   (key_avail),
  .sw_state    (sw_state),
  .slot_sel    (slot_sel)
);

// File: tb/softsw_bank_tb.sv
module softsw_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_rw = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic [7:0]  bus_rdata;
  logic        bus_rdata_oe;
  logic        key_valid = 1'b0;
  logic [6:0]  key_code = 7'h00;
  logic [7:0]  sw_state;
  logic [7:0]  slot_sel;

  int checks = 0;
  int fails  = 0;

  softsw_bank u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_rw(bus_rw),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe),
    .key_valid(key_valid), .key_code(key_code), .sw_state(sw_state),
    .slot_sel(slot_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // vector: {rw, addr, expected switches after edge, expected oe, expected rdata}
  localparam int NV = 13;
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 16'hC051, 8'h01, 1'b0, 8'h00},
    {1'b1, 16'hC055, 8'h05, 1'b1, 8'h01},
    {1'b0, 16'hC05F, 8'h85, 1'b0, 8'h00},
    {1'b1, 16'hC052, 8'h85, 1'b1, 8'h85},
    {1'b0, 16'hC050, 8'h84, 1'b0, 8'h00},
    {1'b1, 16'hC00F, 8'h84, 1'b0, 8'h00},
    {1'b0, 16'hD053, 8'h84, 1'b0, 8'h00},
    {1'b1, 16'hC0D3, 8'h84, 1'b0, 8'h00},
    {1'b1, 16'hC05B, 8'hA4, 1'b1, 8'h84},
    {1'b0, 16'hC054, 8'hA0, 1'b0, 8'h00},
    {1'b1, 16'hC05E, 8'h20, 1'b1, 8'hA0},
    {1'b1, 16'hC05D, 8'h60, 1'b1, 8'h20},
    {1'b1, 16'hC061, 8'h60, 1'b0, 8'h00}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic       cap_oe;
  logic [7:0] cap_rd;
  logic [7:0] cap_slot;

  // one bus cycle: sample combinational outputs before the edge,
  // return 1 ns after the edge so registered state is settled
  task automatic access(input logic rw, input logic [15:0] a);
    @(negedge clk);
    bus_valid = 1'b1;
    bus_rw    = rw;
    bus_addr  = a;
    #1;
    cap_oe   = bus_rdata_oe;
    cap_rd   = bus_rdata;
    cap_slot = slot_sel;
    @(posedge clk);
    #1;
    bus_valid = 1'b0;
  endtask

  task automatic key_pulse(input logic [6:0] code);
    @(negedge clk);
    key_valid = 1'b1;
    key_code  = code;
    @(posedge clk);
    #1;
    key_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    // R1: reset state
    check("R1 switches after reset", 32'(sw_state), 32'h00);
    access(1'b1, 16'hC000);
    check("R1 key flag after reset", 32'(cap_rd), 32'h00);

    // R2 R3 R4 R5 R8 R9 R10 via vector table
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][33], VEC[i][32:17]);
      check($sformatf("R2/R4 vec%0d switches", i), 32'(sw_state), 32'(VEC[i][16:9]));
      check($sformatf("R5/R8/R10 vec%0d oe", i), 32'(cap_oe), 32'(VEC[i][8]));
      check($sformatf("R5 vec%0d rdata", i), 32'(cap_rd), 32'(VEC[i][7:0]));
    end

    // R8: bus_valid low on a switch address changes nothing
    @(negedge clk);
    bus_addr = 16'hC051; bus_rw = 1'b0;
    @(posedge clk); #1;
    check("R8 idle cycle no change", 32'(sw_state), 32'h60);

    // R3: write to clear and read to set the same switch
    access(1'b0, 16'hC05C);
    check("R3 write clears switch6", 32'(sw_state), 32'h20);
    access(1'b1, 16'hC05D);
    check("R3 read sets switch6", 32'(sw_state), 32'h60);

    // R9: slot selects
    access(1'b1, 16'hC0A5);
    check("R9 slot2 select", 32'(cap_slot), 32'h04);
    check("R9 slot no drive", 32'(cap_oe), 32'h0);
    access(1'b0, 16'hC0F0);
    check("R9 slot7 select", 32'(cap_slot), 32'h80);
    access(1'b1, 16'hC025);
    check("R9 motherboard no slot", 32'(cap_slot), 32'h00);
    access(1'b1, 16'hB0A5);
    check("R9 other page no slot", 32'(cap_slot), 32'h00);

    // R6: key latch
    key_pulse(7'h41);
    access(1'b1, 16'hC000);
    check("R6 key read", 32'(cap_rd), 32'hC1);
    check("R6 key oe", 32'(cap_oe), 32'h1);

    // R7: strobe clear by write keeps code
    access(1'b0, 16'hC010);
    access(1'b1, 16'hC000);
    check("R7 strobe clears flag", 32'(cap_rd), 32'h41);

    // R7: key_valid in the same cycle as strobe wins
    @(negedge clk);
    key_valid = 1'b1; key_code = 7'h2A;
    bus_valid = 1'b1; bus_rw = 1'b1; bus_addr = 16'hC010;
    @(posedge clk); #1;
    key_valid = 1'b0; bus_valid = 1'b0;
    access(1'b1, 16'hC000);
    check("R7 key beats strobe", 32'(cap_rd), 32'hAA);

    // R7: strobe by read also clears
    access(1'b1, 16'hC010);
    check("R7 strobe read returns flag", 32'(cap_rd), 32'hAA);
    access(1'b1, 16'hC000);
    check("R7 strobe read clears", 32'(cap_rd), 32'h2A);

    // R1: mid-run reset
    key_pulse(7'h11);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1; rst = 1'b0;
    check("R1 reset clears switches", 32'(sw_state), 32'h00);
    access(1'b1, 16'hC000);
    check("R1 reset clears key flag", 32'(cap_rd[7]), 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule